// File: doc/BRIEF.md
# Fractional pulse-swallow clock-enable divider

This block turns one fast clock into several slower effective rates without a second clock domain. For each channel it drives a one-cycle-wide enable, and downstream logic qualifies its registers with that enable. Each channel has a 5-bit swallow code N. In every 32-cycle window the channel's enable is high on exactly 32 - N cycles, so the average rate is the input rate times (32 - N)/32. The high cycles are spread evenly across the window by a small phase accumulator, not bunched together.

Software writes both channels' codes into one pending-settings register, then sets the update bit in a separate control register. The pending codes move to the active set only on the last cycle of a window, so no window is ever cut short. The update bit reads as 1 until one cycle after that transfer and then clears itself. Software polls it, and if the bit stays set it treats that as a timeout. The register port is a plain one-cycle write strobe with a combinational read mux. Each access completes at once, so the port applies no back-pressure and has no ready signal.

Top module: `psd_divider`

## Requirements
- R1: After reset both active and pending codes are 0, the update bit reads 0, and every channel enable is high on every cycle.
- R2: With active code N, each channel enable is high on exactly 32 - N cycles of any 32 consecutive cycles. Code 0 gives an enable that is always high, and code 31 gives one pulse per window.
- R3: The settings register (select 0) holds channel 1's code in bits 12:8 and channel 0's code in bits 4:0. Channel 1 drives `ch_en[1]` and channel 0 drives `ch_en[0]`. All other bits are not stored and read back as 0.
- R4: A write to the settings register alone leaves the enable patterns unchanged.
- R5: Writing the control register (select 1) with bit 31 set makes bit 31 read as 1 from the next cycle. It clears itself within 33 cycles, and all other control bits read 0.
- R6: Active codes change only on the last cycle of a 32-cycle window. The update bit falls exactly one cycle after that transfer, and from then on both channels run at their new codes.
- R7: A write that sets bit 31 while an update is pending is ignored. Once the bit clears it stays clear with no further write.
- R8: Enables are spread evenly: with code 16 a channel's enable alternates on every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | One-cycle write strobe |
| wr_sel | input | 1 | Write target: 0 settings, 1 control |
| wr_data | input | 32 | Write data |
| rd_sel | input | 1 | Read target: 0 settings, 1 control |
| rd_data | output | 32 | Combinational read data for `rd_sel` |
| ch_en | output | 2 | Per-channel clock enable |

## Verification
A write is sampled at the clock edge that follows the strobe, so read data and the update bit reflect it one cycle later. The bench drives on falling edges and reads on the next falling edge. The enables are combinational from the window state, so each rate check counts them over 32 consecutive falling-edge samples. Each count starts only after the update bit reads 0, when the new codes are known to be active. For R6 the bench polls the update bit once per cycle and requires the fall within 33 cycles of the kick. For R7 it keeps polling for 40 more cycles to confirm the bit never sets again.

// File: rtl/psd_pkg.sv
`timescale 1ns/1ps
package psd_pkg;
  localparam int CODE_W       = 5;
  localparam int WIN          = 1 << CODE_W;
  localparam int DATA_W       = 32;
  localparam int KICK_BIT     = 31;
  localparam int FIELD_STRIDE = 8;
  localparam int NCH          = 2;

  typedef enum logic {
    SEL_PEND = 1'b0,
    SEL_CTRL = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/psd_window.sv
`timescale 1ns/1ps
module psd_window #(
  parameter int CODE_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [CODE_W-1:0] phase,
  output logic              win_last
);
  localparam logic [CODE_W-1:0] LAST = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= '0;
    else        phase <= phase + 1'b1;
  end

  assign win_last = (phase == LAST);
endmodule

// File: rtl/psd_accum.sv
`timescale 1ns/1ps
module psd_accum #(
  parameter int CODE_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] code,
  output logic              en,
  output logic [CODE_W-1:0] acc
);
  localparam int SUM_W = CODE_W + 1;
  localparam logic [SUM_W-1:0] WIN_V = SUM_W'(1 << CODE_W);

  logic [SUM_W-1:0] inc;
  logic [SUM_W-1:0] sum;

  always_comb begin
    inc = WIN_V - {1'b0, code};
    sum = {1'b0, acc} + inc;
  end

  assign en = sum[CODE_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc <= '0;
    else        acc <= sum[CODE_W-1:0];
  end
endmodule

// File: rtl/psd_regs.sv
`timescale 1ns/1ps
module psd_regs
  import psd_pkg::*;
#(
  parameter int CODE_W       = 5,
  parameter int NCH          = 2,
  parameter int DATA_W       = 32,
  parameter int FIELD_STRIDE = 8,
  parameter int KICK_BIT     = 31
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic                       wr_sel,
  input  logic [DATA_W-1:0]          wr_data,
  input  logic                       rd_sel,
  input  logic                       win_last,
  output logic [DATA_W-1:0]          rd_data,
  output logic [NCH-1:0][CODE_W-1:0] act_code,
  output logic                       busy
);
  logic [NCH-1:0][CODE_W-1:0] pend_code;
  logic                       done_q;
  logic                       kick_req;
  logic                       xfer;
  logic [DATA_W-1:0]          pend_view;
  logic [DATA_W-1:0]          ctrl_view;

  assign kick_req = wr_en && (wr_sel == SEL_CTRL) && wr_data[KICK_BIT] && !busy;
  assign xfer     = busy && !done_q && win_last;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend_code[i] <= '0;
        act_code[i]  <= '0;
      end else begin
        if (wr_en && (wr_sel == SEL_PEND))
          pend_code[i] <= wr_data[i*FIELD_STRIDE +: CODE_W];
        if (xfer)
          act_code[i] <= pend_code[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      done_q <= 1'b0;
    end else begin
      if (kick_req)    busy <= 1'b1;
      else if (done_q) busy <= 1'b0;
      done_q <= xfer;
    end
  end

  always_comb begin
    pend_view = '0;
    for (int i = 0; i < NCH; i++)
      pend_view[i*FIELD_STRIDE +: CODE_W] = pend_code[i];
    ctrl_view = '0;
    ctrl_view[KICK_BIT] = busy;
    rd_data = (rd_sel == SEL_CTRL) ? ctrl_view : pend_view;
  end
endmodule

// File: rtl/psd_divider.sv
`timescale 1ns/1ps
module psd_divider
  import psd_pkg::*;
#(
  parameter int CODE_W_P = psd_pkg::CODE_W,
  parameter int NCH_P    = psd_pkg::NCH,
  parameter int DATA_W_P = psd_pkg::DATA_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic                wr_sel,
  input  logic [DATA_W_P-1:0] wr_data,
  input  logic                rd_sel,
  output logic [DATA_W_P-1:0] rd_data,
  output logic [NCH_P-1:0]    ch_en
);
  logic [CODE_W_P-1:0]            phase;
  logic                           win_last;
  logic                           busy;
  logic [NCH_P-1:0][CODE_W_P-1:0] act_code;
  logic [NCH_P-1:0][CODE_W_P-1:0] acc;

  psd_window #(.CODE_W(CODE_W_P)) u_win (
    .clk(clk), .rst_n(rst_n), .phase(phase), .win_last(win_last)
  );

  psd_regs #(
    .CODE_W(CODE_W_P), .NCH(NCH_P), .DATA_W(DATA_W_P),
    .FIELD_STRIDE(FIELD_STRIDE), .KICK_BIT(KICK_BIT)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_sel(rd_sel), .win_last(win_last),
    .rd_data(rd_data), .act_code(act_code), .busy(busy)
  );

  for (genvar i = 0; i < NCH_P; i++) begin : g_acc
    psd_accum #(.CODE_W(CODE_W_P)) u_acc (
      .clk(clk), .rst_n(rst_n), .code(act_code[i]),
      .en(ch_en[i]), .acc(acc[i])
    );
  end
endmodule

// File: rtl/psd_divider_chk.sv
`timescale 1ns/1ps
module psd_divider_chk #(
  parameter int CODE_W_P = 5,
  parameter int NCH_P    = 2,
  parameter int DATA_W_P = 32
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           wr_en,
  input logic                           wr_sel,
  input logic [DATA_W_P-1:0]            wr_data,
  input logic [NCH_P-1:0]               ch_en,
  input logic [CODE_W_P-1:0]            phase,
  input logic                           busy,
  input logic [NCH_P-1:0][CODE_W_P-1:0] act_code,
  input logic [NCH_P-1:0][CODE_W_P-1:0] acc
);
  localparam logic [CODE_W_P-1:0] LAST = '1;

  AST_XFER_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(act_code) |-> ($past(phase) == LAST)) else $error("xfer off boundary"); // R6

  AST_BUSY_FALL_AFTER_XFER: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (phase == 1)) else $error("busy fell late"); // R6

  AST_KICK_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_en && wr_sel && wr_data[31] && phase != 0) |=> busy) else $error("kick dropped busy"); // R7

  AST_IDLE_KEEPS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(act_code)) else $error("active changed idle"); // R4

  for (genvar i = 0; i < NCH_P; i++) begin : g_chk
    AST_CODE0_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      (act_code[i] == 0) |-> ch_en[i]) else $error("code0 gap"); // R2
    AST_WINDOW_REALIGN: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == 0) |-> (acc[i] == 0)) else $error("acc off at window start"); // R2
  end
endmodule

bind psd_divider psd_divider_chk #(
  .CODE_W_P(CODE_W_P), .NCH_P(NCH_P), .DATA_W_P(DATA_W_P)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
  .wr_data(wr_data), .ch_en(ch_en), .phase(phase), .busy(busy),
  .act_code(act_code), .acc(acc)
);

// File: tb/sim_psd_divider.sv
`timescale 1ns/1ps
module sim_psd_divider;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        wr_sel = 1'b0;
  logic [31:0] wr_data = '0;
  logic        rd_sel = 1'b0;
  logic [31:0] rd_data;
  logic [1:0]  ch_en;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  psd_divider u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data), .ch_en(ch_en)
  );

  // {code ch1 (bits 12:8), code ch0 (bits 4:0)}
  localparam logic [9:0] VEC [6] = '{
    {5'd5,  5'd0 }, {5'd31, 5'd16}, {5'd0,  5'd31},
    {5'd16, 5'd1 }, {5'd20, 5'd12}, {5'd0,  5'd0 }
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic rd(input logic sel, output logic [31:0] d);
    rd_sel = sel; #1; d = rd_data;
  endtask

  task automatic count_win(output int c1, output int c0);
    c1 = 0; c0 = 0;
    for (int k = 0; k < 32; k++) begin
      @(negedge clk);
      c1 += int'(ch_en[1]); c0 += int'(ch_en[0]);
    end
  endtask

  // kick, confirm bit 31 set next cycle, poll until clear; returns cycles busy
  task automatic kick_and_wait(output int cyc);
    logic [31:0] d;
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 1'b1; wr_data = 32'h8000_0000;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
    rd(1'b1, d);
    chk("R5 busy after kick", int'(d[31]), 1);
    cyc = 1;
    while (d[31] && cyc < 60) begin
      @(negedge clk); rd(1'b1, d); cyc++;
    end
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int c1, c0, cyc, a, b, pa, pb, prev, alt;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(1'b0, d); chk("R1 pending after reset", int'(d), 0);
    rd(1'b1, d); chk("R1 kick bit after reset", int'(d), 0);
    count_win(c1, c0);
    chk("R1 ch1 full rate", c1, 32);
    chk("R1 ch0 full rate", c0, 32);

    pa = 0; pb = 0;
    foreach (VEC[v]) begin
      a = int'(VEC[v][9:5]); b = int'(VEC[v][4:0]);
      wr(1'b0, (32'(a) << 8) | 32'(b) | 32'hFFFF_E0E0);
      rd(1'b0, d);
      chk("R3 settings readback", int'(d), (a << 8) | b);
      count_win(c1, c0);
      chk("R4 ch1 unchanged before kick", c1, 32 - pa);
      chk("R4 ch0 unchanged before kick", c0, 32 - pb);
      kick_and_wait(cyc);
      chk("R5 kick clears in time", int'(cyc <= 33), 1);
      count_win(c1, c0);
      chk("R2 ch1 rate", c1, 32 - a);
      chk("R2 ch0 rate", c0, 32 - b);
      pa = a; pb = b;
    end

    // R9-style: other control bits read 0 (R5)
    wr(1'b1, 32'h7FFF_FFFF);
    rd(1'b1, d); chk("R5 control other bits zero", int'(d), 0);

    // R8 evenness with code 16 on channel 0
    wr(1'b0, 32'd16);
    kick_and_wait(cyc);
    @(negedge clk); prev = int'(ch_en[0]); alt = 1;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (int'(ch_en[0]) == prev) alt = 0;
      prev = int'(ch_en[0]);
    end
    chk("R8 code16 alternates", alt, 1);
    count_win(c1, c0);
    chk("R3 ch1 follows bits 12:8", c1, 32);
    chk("R3 ch0 follows bits 4:0", c0, 16);

    // R7 kick while pending is ignored
    wr(1'b0, (32'd31 << 8) | 32'd0);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 1'b1; wr_data = 32'h8000_0000;
    @(negedge clk);
    wr_en = 1'b1; // second kick while busy
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
    rd(1'b1, d); chk("R7 busy during pending", int'(d[31]), 1);
    cyc = 0;
    while (d[31] && cyc < 60) begin @(negedge clk); rd(1'b1, d); cyc++; end
    chk("R6 cleared after boundary", int'(d[31]), 0);
    alt = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk); rd(1'b1, d); alt |= int'(d[31]);
    end
    chk("R7 no second update", alt, 0);
    count_win(c1, c0);
    chk("R6 ch1 new rate", c1, 1);
    chk("R6 ch0 new rate", c0, 32);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule